// File: doc/BRIEF.md
# Two-Port Multithreaded SIMD Issue Scheduler

This block sits in front of the execution units of a multithreaded SIMD processor. It holds a fixed set of resident thread slots, one pending instruction each. Every cycle it picks threads that are ready to issue. Each slot carries an occupancy flag, an execution-unit class (ALU or MEM), a latency value and a stall counter. When a thread issues, the counter is loaded from that latency value, and the thread stays ineligible until the counter drains. This lets the scheduler hide long memory latencies by moving to other threads, with no penalty for the switch.

A thread is as wide as two groups of physical lanes. Each instruction therefore streams out over consecutive beats: beat 0 carries element-mask bits 15..0 and beat 1 carries bits 31..16. There are two dispatch ports. Port 0 has precedence. Port 1 may issue in the same cycle, but only from a different thread and only to the other unit class. Each port uses round-robin arbitration with its own pointer. A port that is mid-instruction does not re-arbitrate.

Instructions arrive on a valid/ready load interface addressed by slot. Ready is the emptiness of the addressed slot, so a producer holds its word until that slot drains. The two issue ports have no back-pressure: the execution units take every beat presented.

Top module: `simd_issue_sched`

## Requirements
- R1: A synchronous active-high reset empties every slot, drops both issue valids and sets both round-robin pointers to slot 0. With several slots filled after reset, port 0's first issue is slot 0.
- R2: `ld_ready` is high exactly when the slot addressed by `ld_slot` is empty. A word is written into that slot on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_cls` encodes 0 = ALU and 1 = MEM.
- R3: A slot is eligible in a cycle when it is occupied, its stall counter reads zero, and neither port is streaming that thread's second beat. Issuing a slot empties it.
- R4: On the edge where a slot issues, its stall counter takes that instruction's `ld_lat` value. The counter then drops by one per cycle. A later instruction loaded into the slot stays ineligible while the counter is nonzero.
- R5: Each port searches slots upward from its pointer, wrapping around. After a grant, the pointer moves to the granted slot plus one, modulo the slot count.
- R6: An instruction occupies its port for two consecutive cycles: beat 0 then beat 1. Thread id, class and instruction word are held for both beats. `pN_lanes` shows mask bits 15..0 on beat 0 and bits 31..16 on beat 1. `pN_lanes` is zero while the port is idle.
- R7: When both ports are valid in the same cycle, they show different thread ids and different classes. Port 1 avoids port 0's class for the coming cycle. Port 0 avoids port 1's class while port 1 is about to present its second beat.
- R8: Arbitration happens in a cycle and its beat 0 appears after the next clock edge. `pN_valid` is low in any cycle that follows an arbitration with no eligible candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Addressed slot is empty |
| ld_slot | input | 3 | Slot to load |
| ld_cls | input | 1 | Unit class, 0 = ALU, 1 = MEM |
| ld_lat | input | 4 | Stall cycles applied when this instruction issues |
| ld_instr | input | 32 | Instruction word |
| ld_mask | input | 32 | Per-element active mask |
| p0_valid | output | 1 | Port 0 presents a beat |
| p0_tid | output | 3 | Port 0 thread slot |
| p0_beat | output | 1 | Port 0 beat index |
| p0_lanes | output | 16 | Port 0 lane-group select |
| p0_cls | output | 1 | Port 0 unit class |
| p0_instr | output | 32 | Port 0 instruction word |
| p1_valid | output | 1 | Port 1 presents a beat |
| p1_tid | output | 3 | Port 1 thread slot |
| p1_beat | output | 1 | Port 1 beat index |
| p1_lanes | output | 16 | Port 1 lane-group select |
| p1_cls | output | 1 | Port 1 unit class |
| p1_instr | output | 32 | Port 1 instruction word |

## Verification
The bench uses the default parameters: 8 slots, 16 lanes, 32 elements and a 4-bit latency. With 8 slots and 2 ports, round-robin wrap-around happens within a few dozen cycles. The small latency range lets stall counters expire often, so a reloaded slot racing its own countdown is exercised many times. Two beats per instruction let one port's second beat overlap the other port's fresh grant, which is where the cross-port class and thread exclusion matters. A directed all-MEM fill checks that port 1 stays silent when only one class is present.

// File: rtl/simd_sched_pkg.sv
package simd_sched_pkg;
  typedef enum logic {CLS_ALU = 1'b0, CLS_MEM = 1'b1} unit_cls_e;
endpackage

// File: rtl/simd_rr_pick.sv
module simd_rr_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // first requester at or above base, wrapping
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!hit && req[(int'(base) + k) % N]) begin
        hit = 1'b1;
        idx = IW'((int'(base) + k) % N);
      end
    end
  end
endmodule

// File: rtl/simd_slot_table.sv
module simd_slot_table import simd_sched_pkg::*; #(
  parameter int N       = 8,
  parameter int INSTR_W = 32,
  parameter int ELEMS   = 32,
  parameter int LAT_W   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [IW-1:0]      ld_slot,
  input  unit_cls_e          ld_cls,
  input  logic [LAT_W-1:0]   ld_lat,
  input  logic [INSTR_W-1:0] ld_instr,
  input  logic [ELEMS-1:0]   ld_mask,
  output logic               ld_ready,
  input  logic [N-1:0]       take,
  output logic [N-1:0]       avail,
  output unit_cls_e          s_cls   [N],
  output logic [INSTR_W-1:0] s_instr [N],
  output logic [ELEMS-1:0]   s_mask  [N]
);
  logic [N-1:0] occ;

  assign ld_ready = ~occ[ld_slot];

  for (genvar s = 0; s < N; s++) begin : g_slot
    logic               acc;
    logic [LAT_W-1:0]   cnt, lat_r;
    unit_cls_e          cls_r;
    logic [INSTR_W-1:0] instr_r;
    logic [ELEMS-1:0]   mask_r;

    assign acc = ld_valid && ld_ready && (ld_slot == IW'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        occ[s] <= 1'b0;
        cnt    <= '0;
      end else if (take[s]) begin
        occ[s] <= 1'b0;
        cnt    <= lat_r;
      end else begin
        if (cnt != '0) cnt <= cnt - LAT_W'(1);
        if (acc) occ[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (acc) begin
        lat_r   <= ld_lat;
        cls_r   <= ld_cls;
        instr_r <= ld_instr;
        mask_r  <= ld_mask;
      end
    end

    assign avail[s]   = occ[s] && (cnt == '0);
    assign s_cls[s]   = cls_r;
    assign s_instr[s] = instr_r;
    assign s_mask[s]  = mask_r;
  end
endmodule

// File: rtl/simd_issue_port.sv
module simd_issue_port import simd_sched_pkg::*; #(
  parameter int N       = 8,
  parameter int INSTR_W = 32,
  parameter int ELEMS   = 32,
  parameter int LANES   = 16,
  localparam int IW     = $clog2(N),
  localparam int NBEATS = ELEMS / LANES,
  localparam int BW     = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               grab,
  input  logic [IW-1:0]      g_idx,
  input  unit_cls_e          g_cls,
  input  logic [INSTR_W-1:0] g_instr,
  input  logic [ELEMS-1:0]   g_mask,
  output logic               busy,
  output logic               o_valid,
  output logic [IW-1:0]      o_tid,
  output logic [BW-1:0]      o_beat,
  output logic [LANES-1:0]   o_lanes,
  output unit_cls_e          o_cls,
  output logic [INSTR_W-1:0] o_instr,
  output logic [IW-1:0]      o_ptr
);
  localparam logic [BW-1:0] LAST = BW'(NBEATS - 1);

  logic [ELEMS-1:0] mask_r;

  // more beats of the current instruction still to come
  assign busy = o_valid && (o_beat != LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_beat  <= '0;
      o_ptr   <= '0;
      o_tid   <= '0;
      o_cls   <= CLS_ALU;
    end else if (busy) begin
      o_beat <= o_beat + BW'(1);
    end else if (grab) begin
      o_valid <= 1'b1;
      o_beat  <= '0;
      o_tid   <= g_idx;
      o_cls   <= g_cls;
      o_instr <= g_instr;
      mask_r  <= g_mask;
      o_ptr   <= (g_idx == IW'(N - 1)) ? '0 : g_idx + IW'(1);
    end else begin
      o_valid <= 1'b0;
      o_beat  <= '0;
    end
  end

  always_comb begin
    o_lanes = '0;
    if (o_valid) begin
      for (int b = 0; b < NBEATS; b++) begin
        if (o_beat == BW'(b)) o_lanes = mask_r[b*LANES +: LANES];
      end
    end
  end
endmodule

// File: rtl/simd_issue_sched.sv
module simd_issue_sched import simd_sched_pkg::*; #(
  parameter int N_SLOTS = 8,
  parameter int LANES   = 16,
  parameter int ELEMS   = 32,
  parameter int INSTR_W = 32,
  parameter int LAT_W   = 4,
  localparam int SW     = $clog2(N_SLOTS),
  localparam int NBEATS = ELEMS / LANES,
  localparam int BW     = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [SW-1:0]      ld_slot,
  input  logic               ld_cls,
  input  logic [LAT_W-1:0]   ld_lat,
  input  logic [INSTR_W-1:0] ld_instr,
  input  logic [ELEMS-1:0]   ld_mask,
  output logic               p0_valid,
  output logic [SW-1:0]      p0_tid,
  output logic [BW-1:0]      p0_beat,
  output logic [LANES-1:0]   p0_lanes,
  output logic               p0_cls,
  output logic [INSTR_W-1:0] p0_instr,
  output logic               p1_valid,
  output logic [SW-1:0]      p1_tid,
  output logic [BW-1:0]      p1_beat,
  output logic [LANES-1:0]   p1_lanes,
  output logic               p1_cls,
  output logic [INSTR_W-1:0] p1_instr
);
  unit_cls_e          s_cls   [N_SLOTS];
  logic [INSTR_W-1:0] s_instr [N_SLOTS];
  logic [ELEMS-1:0]   s_mask  [N_SLOTS];
  logic [N_SLOTS-1:0] avail, take, elig, req0, req1;

  logic          busy0, busy1, hit0, hit1, nxt0_act;
  logic [SW-1:0] gidx0, gidx1, ptr0, ptr1;
  unit_cls_e     ocls0, ocls1, nxt0_cls;

  simd_slot_table #(
    .N(N_SLOTS), .INSTR_W(INSTR_W), .ELEMS(ELEMS), .LAT_W(LAT_W)
  ) u_slots (
    .clk, .rst, .ld_valid, .ld_slot,
    .ld_cls(unit_cls_e'(ld_cls)), .ld_lat, .ld_instr, .ld_mask,
    .ld_ready, .take, .avail, .s_cls, .s_instr, .s_mask
  );

  // eligible: ready slot not being streamed; port 0 also avoids the
  // class port 1 keeps for its pending beat
  always_comb begin
    for (int s = 0; s < N_SLOTS; s++) begin
      elig[s] = avail[s]
             && !(busy0 && p0_tid == SW'(s))
             && !(busy1 && p1_tid == SW'(s));
      req0[s] = elig[s] && !(busy1 && s_cls[s] == ocls1);
    end
  end

  simd_rr_pick #(.N(N_SLOTS)) u_pick0 (
    .req(req0), .base(ptr0), .hit(hit0), .idx(gidx0)
  );

  // class that port 0 presents on the coming cycle
  assign nxt0_act = busy0 || hit0;
  assign nxt0_cls = busy0 ? ocls0 : s_cls[gidx0];

  always_comb begin
    for (int s = 0; s < N_SLOTS; s++) begin
      req1[s] = elig[s]
             && !(!busy0 && hit0 && gidx0 == SW'(s))
             && !(nxt0_act && s_cls[s] == nxt0_cls);
    end
  end

  simd_rr_pick #(.N(N_SLOTS)) u_pick1 (
    .req(req1), .base(ptr1), .hit(hit1), .idx(gidx1)
  );

  always_comb begin
    for (int s = 0; s < N_SLOTS; s++) begin
      take[s] = (!busy0 && hit0 && gidx0 == SW'(s))
             || (!busy1 && hit1 && gidx1 == SW'(s));
    end
  end

  simd_issue_port #(
    .N(N_SLOTS), .INSTR_W(INSTR_W), .ELEMS(ELEMS), .LANES(LANES)
  ) u_port0 (
    .clk, .rst, .grab(hit0), .g_idx(gidx0), .g_cls(s_cls[gidx0]),
    .g_instr(s_instr[gidx0]), .g_mask(s_mask[gidx0]),
    .busy(busy0), .o_valid(p0_valid), .o_tid(p0_tid), .o_beat(p0_beat),
    .o_lanes(p0_lanes), .o_cls(ocls0), .o_instr(p0_instr), .o_ptr(ptr0)
  );

  simd_issue_port #(
    .N(N_SLOTS), .INSTR_W(INSTR_W), .ELEMS(ELEMS), .LANES(LANES)
  ) u_port1 (
    .clk, .rst, .grab(hit1), .g_idx(gidx1), .g_cls(s_cls[gidx1]),
    .g_instr(s_instr[gidx1]), .g_mask(s_mask[gidx1]),
    .busy(busy1), .o_valid(p1_valid), .o_tid(p1_tid), .o_beat(p1_beat),
    .o_lanes(p1_lanes), .o_cls(ocls1), .o_instr(p1_instr), .o_ptr(ptr1)
  );

  assign p0_cls = ocls0;
  assign p1_cls = ocls1;
endmodule

// File: rtl/simd_issue_sched_chk.sv
module simd_issue_sched_chk #(
  parameter int SW      = 3,
  parameter int BW      = 1,
  parameter int INSTR_W = 32,
  parameter int LANES   = 16,
  parameter int NBEATS  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               p0_valid,
  input logic [SW-1:0]      p0_tid,
  input logic [BW-1:0]      p0_beat,
  input logic [LANES-1:0]   p0_lanes,
  input logic               p0_cls,
  input logic [INSTR_W-1:0] p0_instr,
  input logic               p1_valid,
  input logic [SW-1:0]      p1_tid,
  input logic [BW-1:0]      p1_beat,
  input logic [LANES-1:0]   p1_lanes,
  input logic               p1_cls,
  input logic [INSTR_W-1:0] p1_instr
);
  localparam logic [BW-1:0] LAST = BW'(NBEATS - 1);

  // R7
  cls_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (p0_valid && p1_valid) |-> (p0_cls != p1_cls));

  // R7
  tid_apart_chk: assert property (@(posedge clk) disable iff (rst)
    (p0_valid && p1_valid) |-> (p0_tid != p1_tid));

  // R6
  p0_beat_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (p0_valid && p0_beat != LAST) |=>
      (p0_valid && p0_beat == $past(p0_beat) + BW'(1)
       && $stable(p0_tid) && $stable(p0_instr) && $stable(p0_cls)));

  // R6
  p1_beat_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (p1_valid && p1_beat != LAST) |=>
      (p1_valid && p1_beat == $past(p1_beat) + BW'(1)
       && $stable(p1_tid) && $stable(p1_instr) && $stable(p1_cls)));

  // R6
  p0_idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    !p0_valid |-> (p0_lanes == '0));

  // R6
  p1_idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    !p1_valid |-> (p1_lanes == '0));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!p0_valid && !p1_valid));
endmodule

bind simd_issue_sched simd_issue_sched_chk #(
  .SW(SW), .BW(BW), .INSTR_W(INSTR_W), .LANES(LANES), .NBEATS(NBEATS)
) u_chk (.*);

// File: tb/simd_issue_sched_tb.sv
`timescale 1ns/1ps
module simd_issue_sched_tb;
  localparam int N = 8;
  localparam int CYCLE_LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        ld_valid = 1'b0, ld_cls = 1'b0;
  logic [2:0]  ld_slot = '0;
  logic [3:0]  ld_lat = '0;
  logic [31:0] ld_instr = '0, ld_mask = '0;
  logic        ld_ready;
  logic        p0_valid, p1_valid, p0_cls, p1_cls;
  logic [2:0]  p0_tid, p1_tid;
  logic [0:0]  p0_beat, p1_beat;
  logic [15:0] p0_lanes, p1_lanes;
  logic [31:0] p0_instr, p1_instr;

  simd_issue_sched u_dut (
    .clk, .rst, .ld_valid, .ld_ready, .ld_slot, .ld_cls, .ld_lat,
    .ld_instr, .ld_mask,
    .p0_valid, .p0_tid, .p0_beat, .p0_lanes, .p0_cls, .p0_instr,
    .p1_valid, .p1_tid, .p1_beat, .p1_lanes, .p1_cls, .p1_instr
  );

  int errs = 0, checks = 0;
  bit done = 0;

  // reference state built from the requirements
  bit        m_v [N];
  int        m_st[N], m_lat[N];
  bit        m_c [N];
  bit [31:0] m_i [N], m_m[N];
  bit        q_v [2], q_c[2];
  int        q_b [2], q_t[2], q_p[2];
  bit [31:0] q_i [2], q_m[2];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int s = 0; s < N; s++) begin m_v[s] = 0; m_st[s] = 0; end
    for (int p = 0; p < 2; p++) begin q_v[p] = 0; q_b[p] = 0; q_p[p] = 0; end
  endfunction

  function automatic bit streaming(int p);
    return q_v[p] && q_b[p] == 0;
  endfunction

  // R3: occupied, counter at zero, not mid-stream on a port
  function automatic bit elig(int s);
    return m_v[s] && m_st[s] == 0
        && !(streaming(0) && q_t[0] == s) && !(streaming(1) && q_t[1] == s);
  endfunction

  function automatic bit [15:0] exp_lanes(int p);
    if (!q_v[p]) return 16'h0;
    return (q_b[p] == 0) ? q_m[p][15:0] : q_m[p][31:16];
  endfunction

  function automatic void model_step();
    bit b0, b1, a0, c0, acc;
    int g0, g1, g[2];
    b0 = streaming(0);
    b1 = streaming(1);
    g0 = -1;
    g1 = -1;
    if (!b0)
      for (int k = 0; k < N; k++) begin
        int s = (q_p[0] + k) % N;
        if (g0 < 0 && elig(s) && !(b1 && m_c[s] == q_c[1])) g0 = s;
      end
    a0 = b0 || g0 >= 0;
    c0 = b0 ? q_c[0] : (g0 >= 0 ? m_c[g0] : 1'b0);
    if (!b1)
      for (int k = 0; k < N; k++) begin
        int s = (q_p[1] + k) % N;
        if (g1 < 0 && elig(s) && s != g0 && !(a0 && m_c[s] == c0)) g1 = s;
      end
    g[0] = g0;
    g[1] = g1;
    acc = ld_valid && !m_v[ld_slot];
    for (int p = 0; p < 2; p++) begin
      if (q_v[p] && q_b[p] == 0) q_b[p] = 1;
      else if (g[p] >= 0) begin
        q_v[p] = 1; q_b[p] = 0; q_t[p] = g[p];
        q_c[p] = m_c[g[p]]; q_i[p] = m_i[g[p]]; q_m[p] = m_m[g[p]];
        q_p[p] = (g[p] + 1) % N;
      end else begin
        q_v[p] = 0; q_b[p] = 0;
      end
    end
    for (int s = 0; s < N; s++) begin
      if (s == g0 || s == g1) begin
        m_v[s] = 0;
        m_st[s] = m_lat[s];   // R4
      end else begin
        if (m_st[s] > 0) m_st[s]--;
        if (acc && int'(ld_slot) == s) begin
          m_v[s] = 1; m_lat[s] = int'(ld_lat); m_c[s] = ld_cls;
          m_i[s] = ld_instr; m_m[s] = ld_mask;
        end
      end
    end
  endfunction

  task automatic compare_outputs();
    chk(p0_valid == q_v[0], "R8 p0 valid", p0_valid, q_v[0]);
    chk(p1_valid == q_v[1], "R8 p1 valid", p1_valid, q_v[1]);
    chk(p0_lanes == exp_lanes(0), "R6 p0 lanes", p0_lanes, exp_lanes(0));
    chk(p1_lanes == exp_lanes(1), "R6 p1 lanes", p1_lanes, exp_lanes(1));
    if (q_v[0]) begin
      chk(int'(p0_tid) == q_t[0], "R3 R4 R5 p0 tid", p0_tid, q_t[0]);
      chk(int'(p0_beat) == q_b[0], "R6 p0 beat", p0_beat, q_b[0]);
      chk(p0_cls == q_c[0], "R7 p0 cls", p0_cls, q_c[0]);
      chk(p0_instr == q_i[0], "R6 p0 instr", p0_instr, q_i[0]);
    end
    if (q_v[1]) begin
      chk(int'(p1_tid) == q_t[1], "R3 R4 R5 p1 tid", p1_tid, q_t[1]);
      chk(int'(p1_beat) == q_b[1], "R6 p1 beat", p1_beat, q_b[1]);
      chk(p1_cls == q_c[1], "R7 p1 cls", p1_cls, q_c[1]);
      chk(p1_instr == q_i[1], "R6 p1 instr", p1_instr, q_i[1]);
    end
  endtask

  // one clock: check at the falling edge, drive, advance the model
  task automatic cycle(bit v, int slot, bit c, int lat, bit [31:0] ins, bit [31:0] msk);
    compare_outputs();
    ld_valid = v; ld_slot = 3'(slot); ld_cls = c; ld_lat = 4'(lat);
    ld_instr = ins; ld_mask = msk;
    #1;
    chk(ld_ready == !m_v[slot], "R2 ld_ready", ld_ready, !m_v[slot]);
    model_step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_reset();
    // R1: nothing issued, every slot empty
    for (int s = 0; s < N; s++) begin
      ld_slot = 3'(s);
      #1;
      chk(ld_ready == 1'b1, "R1 slot empty after reset", ld_ready, 1);
      chk(!p0_valid && !p1_valid, "R1 ports idle after reset", {p0_valid, p1_valid}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(64'(CYCLE_LIMIT) * 8);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // directed: fill all slots, alternating classes, rising latencies
    for (int s = 0; s < N; s++) begin
      cycle(1, s, s[0], s, 32'hC0DE_0000 + 32'(s), {16'(s * 3 + 1), ~16'(s)});
      if (s == 1)
        chk(p0_valid && p0_tid == 3'd0, "R1 first grant is slot 0", p0_tid, 0);
    end
    repeat (30) cycle(0, 0, 0, 0, 0, 0);

    // directed: single class only, port 1 must stay silent
    do_reset();
    for (int s = 0; s < N; s++) cycle(1, s, 1, 0, 32'h5EED_0000 + 32'(s), 32'hFFFF_0001);
    for (int k = 0; k < 20; k++) begin
      chk(!p1_valid, "R7 port 1 idle with one class", p1_valid, 0);
      cycle(0, 0, 0, 0, 0, 0);
    end

    // random traffic
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      int pat = $urandom_range(0, 3);
      bit [31:0] msk = (pat == 0) ? 32'hFFFF_FFFF : (pat == 1) ? 32'h0 : $urandom;
      int lat = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 2);
      cycle($urandom_range(0, 9) < 7, $urandom_range(0, N - 1), 1'($urandom_range(0, 1)),
            lat, $urandom, msk);
    end
    compare_outputs();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule